// File: doc/BRIEF.md
# Run-Time Sized Transmit Queue

This block is a 32-bit-wide first-in first-out queue for words waiting to go out on a serial link. The physical storage has a fixed maximum depth. The capacity actually in use comes from a size field in a control/status word, so software can shrink or grow the queue at run time without changing the hardware. A producer pushes words on the write port. A consumer sees the oldest word on the read port at all times and pops it when it has taken it.

The control/status word reports four occupancy flags: full, almost-full, almost-empty and empty. It also holds a clear command that sets itself back to zero once the flush it started is done. A link-level bus reset empties the queue and puts the flags into their empty state. It keeps the programmed size. A separate active-low hardware reset returns everything, size included, to its defaults.

Top module: `txq_fifo`

## Requirements
- R1: After hardware reset the control/status word reads 0x10000080. That is: empty flag set, all other flags and the clear bit zero, and size 128.
- R2: Accepted words leave in the order they were pushed. `rd_data` always shows the oldest stored word, and a pop takes effect at the clock edge where `rd_en` is high.
- R3: Bit 31 (full) is 1 whenever the stored count is at or above the effective capacity. A push while full is ignored: no word is stored and the count does not change. This holds even when a pop happens in the same cycle.
- R4: Bit 30 (almost-full) is 1 exactly when the stored count equals the effective capacity minus one.
- R5: Bit 29 (almost-empty) is 1 exactly when the queue holds one word.
- R6: Bit 28 (empty) is 1 exactly when the queue holds no word. A pop while empty is ignored.
- R7: A register write loads bits 8:0 of `reg_wdata` into the size field. The field reads back at bits 8:0. The effective capacity is the size, except that a size of 0 gives 1 and a size above the physical depth (256) gives 256.
- R8: A register write with bit 12 set makes bit 12 read 1 from the next cycle. At the following clock edge the queue is emptied and bit 12 returns to 0. Pushes, pops and further clear writes in that cycle are dropped.
- R9: While `bus_rst` is high at a clock edge, the queue is emptied and the clear bit is forced to 0. Any push or pop in that cycle is dropped. The size field is kept.
- R10: A push and a pop in the same cycle, with the queue neither full nor empty, leave the count unchanged and keep the word order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| bus_rst | input | 1 | Synchronous bus reset, flushes the queue |
| wr_en | input | 1 | Push request |
| wr_data | input | 32 | Word to push |
| rd_en | input | 1 | Pop request |
| rd_data | output | 32 | Oldest stored word |
| reg_wr | input | 1 | Control/status word write strobe |
| reg_wdata | input | 32 | Control/status write data (size in 8:0, clear in 12) |
| reg_rdata | output | 32 | Control/status word (flags in 31:28, clear in 12, size in 8:0) |

## Verification
A wrong pointer or count inside this block shows up at the ports no later than the next edge. A bad count moves one of the four flags in `reg_rdata` away from the occupancy the reference queue predicts. A bad read pointer puts the wrong word on `rd_data` as soon as anything is stored. Stuck clear or bus-reset handling shows up one cycle after the command: the empty flag stays low or the clear bit stays high. A lost size write shows up in the readback of bits 8:0 and in a full flag that rises at the wrong count.

// File: rtl/txq_pkg.sv
`timescale 1ns/1ps
package txq_pkg;
    // bit positions inside the 32-bit control/status word
    localparam int REG_W     = 32;
    localparam int FULL_BIT  = 31;
    localparam int AFULL_BIT = 30;
    localparam int AEMPT_BIT = 29;
    localparam int EMPTY_BIT = 28;
    localparam int CLR_BIT   = 12;
    localparam int SIZE_LSB  = 0;

    typedef struct packed {
        logic full;
        logic afull;
        logic aempty;
        logic empty;
    } txq_flags_t;
endpackage

// File: rtl/txq_store.sv
`timescale 1ns/1ps
module txq_store #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 256,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [AW-1:0]     wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [AW-1:0]     rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    logic [DATA_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem_q[wr_addr] <= wr_data;
        end
    end

    assign rd_data = mem_q[rd_addr];
endmodule

// File: rtl/txq_ctrl.sv
`timescale 1ns/1ps
module txq_ctrl
    import txq_pkg::*;
#(
    parameter int DEPTH  = 256,
    parameter int SIZE_W = 9,
    localparam int AW    = $clog2(DEPTH),
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_rst,
    input  logic              flush,
    input  logic              push,
    input  logic              pop,
    input  logic [SIZE_W-1:0] size,
    output logic              mem_we,
    output logic [AW-1:0]     wr_ptr,
    output logic [AW-1:0]     rd_ptr,
    output txq_flags_t        flags
);
    typedef struct packed {
        logic [AW-1:0] wr;
        logic [AW-1:0] rd;
        logic [CW-1:0] cnt;
    } ctrl_t;

    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    ctrl_t    st_q, st_d;
    logic [CW-1:0] cap;
    logic          do_push, do_pop;

    // effective capacity: size clamped into 1..DEPTH
    always_comb begin
        if (size == '0) begin
            cap = CW'(1);
        end else if (32'(size) > 32'(DEPTH)) begin
            cap = CW'(DEPTH);
        end else begin
            cap = CW'(size);
        end
    end

    always_comb begin
        flags.full   = (st_q.cnt >= cap);
        flags.afull  = (st_q.cnt == cap - CW'(1));
        flags.aempty = (st_q.cnt == CW'(1));
        flags.empty  = (st_q.cnt == '0);
    end

    always_comb begin
        st_d    = st_q;
        do_push = push && !flags.full;
        do_pop  = pop && !flags.empty;
        mem_we  = 1'b0;
        if (bus_rst || flush) begin
            st_d = '0;
        end else begin
            if (do_push) begin
                mem_we  = 1'b1;
                st_d.wr = (st_q.wr == LAST) ? '0 : st_q.wr + AW'(1);
            end
            if (do_pop) begin
                st_d.rd = (st_q.rd == LAST) ? '0 : st_q.rd + AW'(1);
            end
            st_d.cnt = st_q.cnt + CW'(do_push) - CW'(do_pop);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign wr_ptr = st_q.wr;
    assign rd_ptr = st_q.rd;
endmodule

// File: rtl/txq_regs.sv
`timescale 1ns/1ps
module txq_regs
    import txq_pkg::*;
#(
    parameter int SIZE_W   = 9,
    parameter int SIZE_RST = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_rst,
    input  logic              reg_wr,
    input  logic [REG_W-1:0]  reg_wdata,
    input  txq_flags_t        flags,
    output logic [SIZE_W-1:0] size,
    output logic              flush,
    output logic [REG_W-1:0]  reg_rdata
);
    typedef struct packed {
        logic [SIZE_W-1:0] size;
        logic              clr;
    } regs_t;

    regs_t rg_q, rg_d;

    always_comb begin
        rg_d = rg_q;
        if (reg_wr) begin
            rg_d.size = reg_wdata[SIZE_LSB +: SIZE_W];
        end
        if (bus_rst || rg_q.clr) begin
            rg_d.clr = 1'b0;
        end else if (reg_wr && reg_wdata[CLR_BIT]) begin
            rg_d.clr = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rg_q <= '{size: SIZE_W'(SIZE_RST), clr: 1'b0};
        end else begin
            rg_q <= rg_d;
        end
    end

    always_comb begin
        reg_rdata                       = '0;
        reg_rdata[FULL_BIT]             = flags.full;
        reg_rdata[AFULL_BIT]            = flags.afull;
        reg_rdata[AEMPT_BIT]            = flags.aempty;
        reg_rdata[EMPTY_BIT]            = flags.empty;
        reg_rdata[CLR_BIT]              = rg_q.clr;
        reg_rdata[SIZE_LSB +: SIZE_W]   = rg_q.size;
    end

    assign size  = rg_q.size;
    assign flush = rg_q.clr;
endmodule

// File: rtl/txq_fifo.sv
`timescale 1ns/1ps
module txq_fifo
    import txq_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int DEPTH    = 256,
    parameter int SIZE_W   = 9,
    parameter int SIZE_RST = 128,
    localparam int AW      = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_rst,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    input  logic              reg_wr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata
);
    logic              mem_we;
    logic [AW-1:0]     wr_ptr;
    logic [AW-1:0]     rd_ptr;
    logic [SIZE_W-1:0] size;
    logic              flush;
    txq_flags_t        flags;

    txq_regs #(.SIZE_W(SIZE_W), .SIZE_RST(SIZE_RST)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_rst   (bus_rst),
        .reg_wr    (reg_wr),
        .reg_wdata (reg_wdata),
        .flags     (flags),
        .size      (size),
        .flush     (flush),
        .reg_rdata (reg_rdata)
    );

    txq_ctrl #(.DEPTH(DEPTH), .SIZE_W(SIZE_W)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .bus_rst (bus_rst),
        .flush   (flush),
        .push    (wr_en),
        .pop     (rd_en),
        .size    (size),
        .mem_we  (mem_we),
        .wr_ptr  (wr_ptr),
        .rd_ptr  (rd_ptr),
        .flags   (flags)
    );

    txq_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
        .clk     (clk),
        .we      (mem_we),
        .wr_addr (wr_ptr),
        .wr_data (wr_data),
        .rd_addr (rd_ptr),
        .rd_data (rd_data)
    );
endmodule

// File: rtl/txq_fifo_chk.sv
`timescale 1ns/1ps
module txq_fifo_chk
    import txq_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             bus_rst,
    input logic             wr_en,
    input logic             rd_en,
    input logic             reg_wr,
    input logic [REG_W-1:0] reg_wdata,
    input logic [REG_W-1:0] reg_rdata
);
    // R3
    full_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rdata[FULL_BIT] && wr_en && !rd_en && !reg_wr && !bus_rst && !reg_rdata[CLR_BIT])
        |=> (reg_rdata[FULL_BIT] && $stable(reg_rdata[AEMPT_BIT])));

    // R6
    empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rdata[EMPTY_BIT] && rd_en && !wr_en && !bus_rst)
        |=> reg_rdata[EMPTY_BIT]);

    // R9
    bus_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rst |=> (reg_rdata[EMPTY_BIT] && !reg_rdata[CLR_BIT] && !reg_rdata[FULL_BIT]));

    // R8
    clear_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[CLR_BIT] |=> (!reg_rdata[CLR_BIT] && reg_rdata[EMPTY_BIT]));

    // R5
    level_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({reg_rdata[FULL_BIT], reg_rdata[EMPTY_BIT]}) && $onehot0({reg_rdata[AEMPT_BIT], reg_rdata[EMPTY_BIT]}));

    // R7
    size_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |=> (reg_rdata[SIZE_LSB +: 9] == $past(reg_wdata[SIZE_LSB +: 9])));
endmodule

bind txq_fifo txq_fifo_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_rst   (bus_rst),
    .wr_en     (wr_en),
    .rd_en     (rd_en),
    .reg_wr    (reg_wr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata)
);

// File: tb/sim_txq_fifo.sv
`timescale 1ns/1ps
module sim_txq_fifo;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_rst = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic        rd_en = 1'b0;
    logic [31:0] rd_data;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;

    int n_chk = 0;
    int n_err = 0;
    bit done = 0;

    logic [31:0] m_q[$];
    int          m_size = 128;
    bit          m_clr = 0;

    always #10 clk = ~clk;

    txq_fifo u0 (
        .clk(clk), .rst_n(rst_n), .bus_rst(bus_rst),
        .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data),
        .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
    );

    function automatic int cap_of(int s);
        if (s == 0) return 1;
        if (s > 256) return 256;
        return s;
    endfunction

    task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic model_update(bit we, logic [31:0] wd, bit re, bit rw, logic [31:0] rwd, bit br);
        int  c    = cap_of(m_size);
        bit  full = (m_q.size() >= c);
        bit  pclr = m_clr;
        if (br || pclr) begin
            m_q.delete();
            m_clr = 0;
        end else begin
            if (re && m_q.size() > 0) void'(m_q.pop_front());
            if (we && !full) m_q.push_back(wd);
            if (rw && rwd[12]) m_clr = 1;
        end
        if (rw) m_size = int'(rwd[8:0]);
    endtask

    task automatic compare();
        int n = m_q.size();
        int c = cap_of(m_size);
        chk(reg_rdata[31] == (n >= c),    "R3 full",         {31'd0, reg_rdata[31]}, {31'd0, n >= c});
        chk(reg_rdata[30] == (n == c - 1), "R4 almost-full", {31'd0, reg_rdata[30]}, {31'd0, n == c - 1});
        chk(reg_rdata[29] == (n == 1),    "R5 almost-empty", {31'd0, reg_rdata[29]}, {31'd0, n == 1});
        chk(reg_rdata[28] == (n == 0),    "R6 empty",        {31'd0, reg_rdata[28]}, {31'd0, n == 0});
        chk(reg_rdata[12] == m_clr,       "R8 clear bit",    {31'd0, reg_rdata[12]}, {31'd0, m_clr});
        chk(reg_rdata[8:0] == 9'(m_size), "R7 size",         {23'd0, reg_rdata[8:0]}, 32'(m_size));
        chk(reg_rdata[27:13] == '0 && reg_rdata[11:9] == '0, "R1 unused bits", reg_rdata, reg_rdata & 32'hF000_11FF);
        if (n > 0) chk(rd_data == m_q[0], "R2 order", rd_data, m_q[0]);
    endtask

    task automatic step(bit we, logic [31:0] wd, bit re, bit rw, logic [31:0] rwd, bit br);
        wr_en = we; wr_data = wd; rd_en = re;
        reg_wr = rw; reg_wdata = rwd; bus_rst = br;
        @(posedge clk);
        model_update(we, wd, re, rw, rwd, br);
        @(negedge clk);
        compare();
    endtask

    task automatic idle();
        step(0, '0, 0, 0, '0, 0);
    endtask

    task automatic set_size(int s);
        step(0, '0, 0, 1, 32'(s), 0);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    endtask

    initial begin
        #(20.0 * 200000);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset value
        chk(reg_rdata == 32'h1000_0080, "R1 reset word", reg_rdata, 32'h1000_0080);
        compare();

        // R3/R4/R6: small capacity, overfill and overdrain
        set_size(4);
        for (int i = 0; i < 6; i++) step(1, 32'hA000_0000 + 32'(i), 0, 0, '0, 0);
        chk(reg_rdata[31] == 1'b1, "R3 full after overfill", reg_rdata, reg_rdata | 32'h8000_0000);
        step(1, 32'hDEAD_BEEF, 1, 0, '0, 0);   // full: push dropped, pop taken
        for (int i = 0; i < 6; i++) step(0, '0, 1, 0, '0, 0);
        chk(reg_rdata[28] == 1'b1, "R6 empty after overdrain", reg_rdata, reg_rdata | 32'h1000_0000);

        // R10: simultaneous push and pop in the middle
        set_size(16);
        for (int i = 0; i < 3; i++) step(1, 32'hB000_0000 + 32'(i), 0, 0, '0, 0);
        for (int i = 0; i < 4; i++) begin
            step(1, 32'hC000_0000 + 32'(i), 1, 0, '0, 0);
            chk(rd_data == m_q[0] && m_q.size() == 3 && reg_rdata[31:28] == 4'b0000,
                "R10 push+pop", rd_data, m_q[0]);
        end

        // R8: clear with data present, push in flush cycle dropped
        step(0, '0, 0, 1, 32'h0000_1010, 0);
        chk(reg_rdata[12] == 1'b1, "R8 clear pending", reg_rdata, reg_rdata | 32'h0000_1000);
        step(1, 32'h1234_5678, 1, 1, 32'h0000_1010, 0);
        chk(reg_rdata == 32'h1000_0010, "R8 flushed", reg_rdata, 32'h1000_0010);

        // R9: bus reset keeps size, empties queue
        for (int i = 0; i < 5; i++) step(1, 32'hD000_0000 + 32'(i), 0, 0, '0, 0);
        step(0, '0, 0, 1, 32'h0000_1010, 0);
        step(1, 32'h5555_5555, 1, 0, '0, 1);
        chk(reg_rdata == 32'h1000_0010, "R9 bus reset", reg_rdata, 32'h1000_0010);
        idle();

        // R7: size 0 behaves as capacity 1
        set_size(0);
        step(1, 32'hE000_0001, 0, 0, '0, 0);
        step(1, 32'hE000_0002, 0, 0, '0, 0);
        chk(reg_rdata[31] == 1'b1 && rd_data == 32'hE000_0001, "R7 size zero", rd_data, 32'hE000_0001);
        step(0, '0, 1, 0, '0, 0);

        // R7: oversize clamps to physical depth
        set_size(300);
        for (int i = 0; i < 260; i++) step(1, 32'hF000_0000 + 32'(i), 0, 0, '0, 0);
        chk(reg_rdata[31] == 1'b1 && m_q.size() == 256, "R7 clamp", 32'(m_q.size()), 32'd256);
        for (int i = 0; i < 258; i++) step(0, '0, 1, 0, '0, 0);

        // random traffic with occasional size, clear and bus reset
        set_size(8);
        for (int i = 0; i < 2000; i++) begin
            bit          we  = ($urandom % 3) != 0;
            bit          re  = ($urandom % 2) != 0;
            bit          rw  = ($urandom % 50) == 0;
            bit          br  = ($urandom % 80) == 0;
            logic [31:0] rwd = 32'(1 + $urandom % 12) | ((($urandom % 3) == 0) ? 32'h0000_1000 : 32'h0);
            step(we, $urandom, re, rw, rwd, br);
        end

        finish_run();
    end
endmodule